// File: doc/BRIEF.md
# Branch and Set-Compare Resolver

This block decides, for one instruction per cycle, whether a conditional branch or a jump leaves the sequential path, and where it goes. It also produces the 0/1 result of the set-on-less-than family of a 32-bit load-store processor. The decode stage presents an operation code, the two source register values, the 16-bit immediate, a 26-bit jump index and the instruction's PC. One clock later the block returns four results:

- the taken flag and the target address,
- a request to write the return address into register 31,
- the compare result with its write enable,
- a valid flag.

The branch target is PC+4 plus the sign-extended immediate shifted left by two. Jump-and-link keeps the upper four bits of PC+4 and concatenates the jump index and two zero bits. Jump-register goes to the value of the first source register. The link variants of the compare-with-zero branches request the register-31 write whether or not the branch is taken.

Top module: `bcu_top`

## Requirements
- R1: A synchronous active-low reset clears every output to zero at the next rising edge, and reset wins over a valid input in that cycle.
- R2: All results appear exactly one cycle after the input is presented. valid_o repeats valid_i. When valid_i is low, taken, link write and set write are all low and the data outputs are zero.
- R3: Code 1 is taken when rs equals rt. Code 2 is taken when rs differs from rt.
- R4: Codes 3, 4, 5 and 6 test rs as a signed value against zero: <=0, >0, <0 and >=0 respectively.
- R5: For codes 1 to 8 the target is PC+4 plus the sign-extended immediate shifted left by 2, whether or not the branch is taken.
- R6: Codes 7 (taken when rs<0) and 8 (taken when rs>=0) always request a link write. The write carries data PC+4 and destination 31. No other code except 9 requests a link write, and otherwise the link data and destination are zero.
- R7: Code 9 is always taken. Its target is {PC+4 bits 31:28, jump index, 2'b00}. It requests a link write of PC+4 to register 31.
- R8: Code 10 is always taken with target equal to rs and no link write.
- R9: Code 11 sets 1 when rs<rt as two's complement numbers. Code 12 sets 1 when rs<rt as natural numbers. Both set 0 otherwise.
- R10: Codes 13 (signed) and 14 (unsigned) compare rs against the sign-extended immediate. Code 14 compares the extended value as unsigned.
- R11: Codes 11 to 14 raise set write with a value of 0 or 1 in bit 0 and never raise taken; their target is 0. Code 0 and codes 15 and above raise nothing and give zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code (see requirements) |
| rs_i | input | 32 | First source register value |
| rt_i | input | 32 | Second source register value |
| imm_i | input | 16 | Immediate field |
| jidx_i | input | 26 | Jump index for jump-and-link |
| pc_i | input | 32 | Address of the instruction |
| valid_o | output | 1 | Results valid |
| taken_o | output | 1 | Control transfer taken |
| target_o | output | 32 | Transfer target address |
| link_we_o | output | 1 | Return-address write request |
| link_data_o | output | 32 | Return address (PC+4) |
| link_rd_o | output | 5 | Destination register of the link write |
| set_we_o | output | 1 | Compare result write request |
| set_val_o | output | 32 | Compare result, 0 or 1 |

## Verification
The and-link branches are the one place where two functions fire in the same cycle: the branch decision and the register-31 write. The bench drives both link codes with rs on each side of zero, including the most negative value and zero itself. In every case it expects the link write with PC+4, and it expects taken only on the side the condition selects. A checker property also ties each link-branch input to a link write one cycle later carrying the sampled PC plus four.

// File: rtl/bcu_pkg.sv
// Package: shared operation codes and decode helpers for the branch and
// set-compare resolver. Assumes a 4-bit operation code supplied by decode.
package bcu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 4'd0,
        OP_BEQ    = 4'd1,
        OP_BNE    = 4'd2,
        OP_BLEZ   = 4'd3,
        OP_BGTZ   = 4'd4,
        OP_BLTZ   = 4'd5,
        OP_BGEZ   = 4'd6,
        OP_BLTZL  = 4'd7,
        OP_BGEZL  = 4'd8,
        OP_JLINK  = 4'd9,
        OP_JREG   = 4'd10,
        OP_SLT    = 4'd11,
        OP_SLTU   = 4'd12,
        OP_SLTI   = 4'd13,
        OP_SLTIU  = 4'd14
    } bcu_op_e;

    // PC-relative branch using the immediate as offset
    function automatic logic is_rel_branch(input logic [OP_W-1:0] op);
        return (op >= OP_BEQ) && (op <= OP_BGEZL);
    endfunction

    // Operation requests a register-31 write
    function automatic logic is_link(input logic [OP_W-1:0] op);
        return (op == OP_BLTZL) || (op == OP_BGEZL) || (op == OP_JLINK);
    endfunction

    // Operation writes a compare result
    function automatic logic is_set(input logic [OP_W-1:0] op);
        return (op >= OP_SLT) && (op <= OP_SLTIU);
    endfunction

endpackage

// File: rtl/bcu_target.sv
// Module: computes PC+4 and the transfer target for every control op.
// Assumes XLEN > JIDX_W + 2 so the jump keeps some upper PC bits.
module bcu_target
    import bcu_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 16,
    parameter int JIDX_W = 26
) (
    input  logic [OP_W-1:0]   op,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   rs,
    input  logic [IMM_W-1:0]  imm,
    input  logic [JIDX_W-1:0] jidx,
    output logic [XLEN-1:0]   pc_next,
    output logic [XLEN-1:0]   target
);
    localparam int ALIGN  = 2;
    localparam int KEEP_W = XLEN - JIDX_W - ALIGN;

    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] abs_tgt;

    // Purpose: sequential address, scaled offset and both target forms
    always_comb begin
        pc_next = pc + XLEN'(4);
        imm_sx  = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        rel_tgt = pc_next + (imm_sx << ALIGN);
        abs_tgt = {pc_next[XLEN-1 -: KEEP_W], jidx, {ALIGN{1'b0}}};
    end

    // Purpose: pick the target that belongs to the operation
    always_comb begin
        if (is_rel_branch(op)) begin
            target = rel_tgt;
        end else if (op == OP_JLINK) begin
            target = abs_tgt;
        end else if (op == OP_JREG) begin
            target = rs;
        end else begin
            target = '0;
        end
    end
endmodule

// File: rtl/bcu_cond.sv
// Module: evaluates whether a control op leaves the sequential path.
// Assumes rs and rt are two's complement values; non-control ops give 0.
module bcu_cond
    import bcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [XLEN-1:0] rs,
    input  logic [XLEN-1:0] rt,
    output logic            take
);
    logic same;
    logic neg;
    logic zero;

    // Purpose: primitive comparisons shared by all conditions
    always_comb begin
        same = (rs == rt);
        neg  = rs[XLEN-1];
        zero = (rs == '0);
    end

    // Purpose: map the operation to its condition
    always_comb begin
        unique case (op)
            OP_BEQ:              take = same;
            OP_BNE:              take = !same;
            OP_BLEZ:             take = neg || zero;
            OP_BGTZ:             take = !neg && !zero;
            OP_BLTZ, OP_BLTZL:   take = neg;
            OP_BGEZ, OP_BGEZL:   take = !neg;
            OP_JLINK, OP_JREG:   take = 1'b1;
            default:             take = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcu_setcmp.sv
// Module: set-on-less-than in signed and unsigned, register and immediate
// forms. Assumes the immediate is always sign-extended, also for unsigned.
module bcu_setcmp
    import bcu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [OP_W-1:0]  op,
    input  logic [XLEN-1:0]  rs,
    input  logic [XLEN-1:0]  rt,
    input  logic [IMM_W-1:0] imm,
    output logic             lt
);
    logic [XLEN-1:0] rhs;
    logic            uns;

    // Purpose: choose the right-hand operand and the number system
    always_comb begin
        if ((op == OP_SLTI) || (op == OP_SLTIU)) begin
            rhs = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        end else begin
            rhs = rt;
        end
        uns = (op == OP_SLTU) || (op == OP_SLTIU);
    end

    // Purpose: single less-than compare in the selected number system
    always_comb begin
        if (uns) begin
            lt = (rs < rhs);
        end else begin
            lt = ($signed(rs) < $signed(rhs));
        end
    end
endmodule

// File: rtl/bcu_top.sv
// Module: top of the branch and set-compare resolver. Combines the
// condition, target and compare units and registers all results once.
// Assumes one operation per cycle, qualified by valid_i.
module bcu_top
    import bcu_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int IMM_W    = 16,
    parameter int JIDX_W   = 26,
    parameter int RD_W     = 5,
    parameter int LINK_REG = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [XLEN-1:0]   rs_i,
    input  logic [XLEN-1:0]   rt_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [JIDX_W-1:0] jidx_i,
    input  logic [XLEN-1:0]   pc_i,
    output logic              valid_o,
    output logic              taken_o,
    output logic [XLEN-1:0]   target_o,
    output logic              link_we_o,
    output logic [XLEN-1:0]   link_data_o,
    output logic [RD_W-1:0]   link_rd_o,
    output logic              set_we_o,
    output logic [XLEN-1:0]   set_val_o
);
    localparam logic [RD_W-1:0] LINK_IDX = RD_W'(LINK_REG);

    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] tgt;
    logic            take;
    logic            lt;
    logic            do_link;
    logic            do_set;

    bcu_target #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_target (
        .op      (op_i),
        .pc      (pc_i),
        .rs      (rs_i),
        .imm     (imm_i),
        .jidx    (jidx_i),
        .pc_next (pc_next),
        .target  (tgt)
    );

    bcu_cond #(.XLEN(XLEN)) u_cond (
        .op   (op_i),
        .rs   (rs_i),
        .rt   (rt_i),
        .take (take)
    );

    bcu_setcmp #(.XLEN(XLEN), .IMM_W(IMM_W)) u_setcmp (
        .op  (op_i),
        .rs  (rs_i),
        .rt  (rt_i),
        .imm (imm_i),
        .lt  (lt)
    );

    // Purpose: qualify link and set requests with the input valid
    always_comb begin
        do_link = valid_i && is_link(op_i);
        do_set  = valid_i && is_set(op_i);
    end

    // Purpose: result register stage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o     <= 1'b0;
            taken_o     <= 1'b0;
            target_o    <= '0;
            link_we_o   <= 1'b0;
            link_data_o <= '0;
            link_rd_o   <= '0;
            set_we_o    <= 1'b0;
            set_val_o   <= '0;
        end else begin
            valid_o     <= valid_i;
            taken_o     <= valid_i && take;
            target_o    <= valid_i ? tgt : '0;
            link_we_o   <= do_link;
            link_data_o <= do_link ? pc_next : '0;
            link_rd_o   <= do_link ? LINK_IDX : '0;
            set_we_o    <= do_set;
            set_val_o   <= do_set ? XLEN'(lt) : '0;
        end
    end
endmodule

// File: rtl/bcu_chk.sv
// Checker: temporal properties of the resolver, bound to bcu_top.
module bcu_chk
    import bcu_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int RD_W     = 5,
    parameter int LINK_REG = 31
) (
    input logic            clk,
    input logic            rst_n,
    input logic            valid_i,
    input logic [3:0]      op_i,
    input logic [XLEN-1:0] rs_i,
    input logic [XLEN-1:0] pc_i,
    input logic            valid_o,
    input logic            taken_o,
    input logic [XLEN-1:0] target_o,
    input logic            link_we_o,
    input logic [XLEN-1:0] link_data_o,
    input logic [RD_W-1:0] link_rd_o,
    input logic            set_we_o,
    input logic [XLEN-1:0] set_val_o
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (!taken_o && !link_we_o && !set_we_o)); // R2

    AST_LINK_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_rd_o == RD_W'(LINK_REG))); // R6

    AST_LINK_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ((op_i == OP_BLTZL) || (op_i == OP_BGEZL)))
        |=> (link_we_o && (link_data_o == $past(pc_i) + XLEN'(4)))); // R6

    AST_JREG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == OP_JREG))
        |=> (taken_o && (target_o == $past(rs_i)) && !link_we_o)); // R8

    AST_SET_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        set_we_o |-> (set_val_o[XLEN-1:1] == '0)); // R11

    AST_SET_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        set_we_o |-> !taken_o); // R11
endmodule

bind bcu_top bcu_chk #(.XLEN(XLEN), .RD_W(RD_W), .LINK_REG(LINK_REG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .op_i        (op_i),
    .rs_i        (rs_i),
    .pc_i        (pc_i),
    .valid_o     (valid_o),
    .taken_o     (taken_o),
    .target_o    (target_o),
    .link_we_o   (link_we_o),
    .link_data_o (link_data_o),
    .link_rd_o   (link_rd_o),
    .set_we_o    (set_we_o),
    .set_val_o   (set_val_o)
);

// File: tb/bcu_top_tb.sv
module bcu_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 25;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] rs;
        logic [31:0] rt;
        logic [15:0] imm;
        logic [25:0] jidx;
        logic [31:0] pc;
        logic        taken;
        logic [31:0] tgt;
        logic        link;
        logic [31:0] ldata;
        logic        setwe;
        logic        setv;
        logic [7:0]  req;
    } vec_t;

    // op, rs, rt, imm, jidx, pc, taken, target, link, ldata, setwe, setv, req
    localparam vec_t VECS [NV] = '{
        '{4'd1, 32'd5, 32'd5, 16'h0004, 26'd0, 32'h1000, 1'b1, 32'h1014, 1'b0, 32'h0, 1'b0, 1'b0, 8'd3},         // R3 equal taken, R5
        '{4'd1, 32'd5, 32'd6, 16'h0004, 26'd0, 32'h1000, 1'b0, 32'h1014, 1'b0, 32'h0, 1'b0, 1'b0, 8'd3},         // R3
        '{4'd2, 32'd5, 32'd6, 16'hFFFF, 26'd0, 32'h1000, 1'b1, 32'h1000, 1'b0, 32'h0, 1'b0, 1'b0, 8'd3},         // R3 negative offset
        '{4'd2, 32'd7, 32'd7, 16'hFFFF, 26'd0, 32'h1000, 1'b0, 32'h1000, 1'b0, 32'h0, 1'b0, 1'b0, 8'd3},         // R3
        '{4'd3, 32'd0, 32'd9, 16'h0008, 26'd0, 32'h1000, 1'b1, 32'h1024, 1'b0, 32'h0, 1'b0, 1'b0, 8'd4},         // R4 <=0 at zero
        '{4'd3, 32'd1, 32'd0, 16'h0008, 26'd0, 32'h1000, 1'b0, 32'h1024, 1'b0, 32'h0, 1'b0, 1'b0, 8'd4},         // R4
        '{4'd4, 32'd0, 32'd0, 16'h0008, 26'd0, 32'h1000, 1'b0, 32'h1024, 1'b0, 32'h0, 1'b0, 1'b0, 8'd4},         // R4 >0 at zero
        '{4'd4, 32'h7FFFFFFF, 32'd0, 16'h0008, 26'd0, 32'h1000, 1'b1, 32'h1024, 1'b0, 32'h0, 1'b0, 1'b0, 8'd4},  // R4
        '{4'd5, 32'h80000000, 32'd0, 16'h0008, 26'd0, 32'h1000, 1'b1, 32'h1024, 1'b0, 32'h0, 1'b0, 1'b0, 8'd4},  // R4
        '{4'd5, 32'd0, 32'd0, 16'h0008, 26'd0, 32'h1000, 1'b0, 32'h1024, 1'b0, 32'h0, 1'b0, 1'b0, 8'd4},         // R4
        '{4'd6, 32'd0, 32'd0, 16'h0008, 26'd0, 32'h1000, 1'b1, 32'h1024, 1'b0, 32'h0, 1'b0, 1'b0, 8'd4},         // R4 >=0 at zero
        '{4'd6, 32'hFFFFFFFF, 32'd0, 16'h0008, 26'd0, 32'h1000, 1'b0, 32'h1024, 1'b0, 32'h0, 1'b0, 1'b0, 8'd4},  // R4
        '{4'd7, 32'hFFFFFFFF, 32'd0, 16'h8000, 26'd0, 32'h1000, 1'b1, 32'hFFFE1004, 1'b1, 32'h1004, 1'b0, 1'b0, 8'd6}, // R6 taken, R5 min offset
        '{4'd7, 32'd3, 32'd0, 16'h0002, 26'd0, 32'h1000, 1'b0, 32'h100C, 1'b1, 32'h1004, 1'b0, 1'b0, 8'd6},      // R6 link while not taken
        '{4'd8, 32'd0, 32'd0, 16'h0002, 26'd0, 32'h1000, 1'b1, 32'h100C, 1'b1, 32'h1004, 1'b0, 1'b0, 8'd6},      // R6
        '{4'd8, 32'h80000000, 32'd0, 16'h0002, 26'd0, 32'h1000, 1'b0, 32'h100C, 1'b1, 32'h1004, 1'b0, 1'b0, 8'd6}, // R6 link while not taken
        '{4'd9, 32'd0, 32'd0, 16'h0000, 26'h100, 32'hA0001000, 1'b1, 32'hA0000400, 1'b1, 32'hA0001004, 1'b0, 1'b0, 8'd7}, // R7
        '{4'd10, 32'h2468, 32'd0, 16'h0000, 26'd0, 32'h1000, 1'b1, 32'h2468, 1'b0, 32'h0, 1'b0, 1'b0, 8'd8},     // R8
        '{4'd11, 32'hFFFFFFFF, 32'd1, 16'h0000, 26'd0, 32'h1000, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1, 8'd9},    // R9 signed
        '{4'd12, 32'hFFFFFFFF, 32'd1, 16'h0000, 26'd0, 32'h1000, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 8'd9},    // R9 unsigned
        '{4'd11, 32'd5, 32'd5, 16'h0000, 26'd0, 32'h1000, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 8'd9},           // R9 equal
        '{4'd13, 32'hFFFFFFFE, 32'd0, 16'hFFFF, 26'd0, 32'h1000, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1, 8'd10},   // R10
        '{4'd14, 32'd5, 32'd0, 16'hFFFF, 26'd0, 32'h1000, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1, 8'd10},          // R10 extended then unsigned
        '{4'd14, 32'hFFFFFFFF, 32'd0, 16'hFFFF, 26'd0, 32'h1000, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 8'd10},   // R10
        '{4'd0, 32'd1, 32'd1, 16'h0004, 26'h5, 32'h1000, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 8'd11}            // R11 no-op
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] rs_i = '0;
    logic [31:0] rt_i = '0;
    logic [15:0] imm_i = '0;
    logic [25:0] jidx_i = '0;
    logic [31:0] pc_i = '0;
    logic        valid_o, taken_o, link_we_o, set_we_o;
    logic [31:0] target_o, link_data_o, set_val_o;
    logic [4:0]  link_rd_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcu_top dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .rs_i(rs_i), .rt_i(rt_i), .imm_i(imm_i), .jidx_i(jidx_i), .pc_i(pc_i),
        .valid_o(valid_o), .taken_o(taken_o), .target_o(target_o),
        .link_we_o(link_we_o), .link_data_o(link_data_o), .link_rd_o(link_rd_o),
        .set_we_o(set_we_o), .set_val_o(set_val_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_quiet(input string req);
        chk(req, "valid", 32'(valid_o), 32'd0);
        chk(req, "taken", 32'(taken_o), 32'd0);
        chk(req, "target", target_o, 32'd0);
        chk(req, "link_we", 32'(link_we_o), 32'd0);
        chk(req, "link_data", link_data_o, 32'd0);
        chk(req, "link_rd", 32'(link_rd_o), 32'd0);
        chk(req, "set_we", 32'(set_we_o), 32'd0);
        chk(req, "set_val", set_val_o, 32'd0);
    endtask

    task automatic drive(input vec_t v, input logic vld);
        valid_i = vld; op_i = v.op; rs_i = v.rs; rt_i = v.rt;
        imm_i = v.imm; jidx_i = v.jidx; pc_i = v.pc;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_quiet("R1");
        rst_n = 1'b1;

        // Table walk: one vector per cycle, checked one cycle later (R2)
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            string rq;
            drive(VECS[i], 1'b1);
            @(negedge clk);
            rq = $sformatf("R%0d(vec %0d)", VECS[i].req, i);
            chk(rq, "valid", 32'(valid_o), 32'd1);
            chk(rq, "taken", 32'(taken_o), 32'(VECS[i].taken));
            chk(rq, "target", target_o, VECS[i].tgt);
            chk(rq, "link_we", 32'(link_we_o), 32'(VECS[i].link));
            chk(rq, "link_data", link_data_o, VECS[i].ldata);
            chk(rq, "link_rd", 32'(link_rd_o), VECS[i].link ? 32'd31 : 32'd0);
            chk(rq, "set_we", 32'(set_we_o), 32'(VECS[i].setwe));
            chk(rq, "set_val", set_val_o, 32'(VECS[i].setv));
        end

        // R2: valid low with an equal-compare link branch gives quiet outputs
        drive('{4'd8, 32'd0, 32'd0, 16'h0002, 26'd0, 32'h1000, 1'b0, 32'h0,
                1'b0, 32'h0, 1'b0, 1'b0, 8'd2}, 1'b0);
        @(negedge clk);
        check_quiet("R2");

        // R1: reset wins over a valid jump in the same cycle
        drive(VECS[16], 1'b1);
        @(negedge clk);
        chk("R7", "taken before reset", 32'(taken_o), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check_quiet("R1");
        rst_n = 1'b1;
        drive(VECS[17], 1'b1);
        @(negedge clk);
        chk("R8", "target after reset", target_o, 32'h2468);
        valid_i = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule